// File: doc/BRIEF.md
# Four-Bank DRAM Command Timing Guard

This block sits between a memory controller's command sequencer and the DRAM command pins. Each cycle the sequencer offers one command with a bank number. The guard looks at four per-bank state records and a few timers shared by all banks. It raises a grant in the same cycle if the command breaks no spacing rule. Otherwise it leaves the grant low, and the sequencer holds the command until the grant comes. A command is never dropped.

On a grant, the guard updates the bank's open/closed state and reloads the down-counters that the command starts. Every minimum delay is a parameter counted in clock cycles. The defaults are the nanosecond limits of a double-data-rate part rounded up at a 7.5 ns clock. Read and write with auto precharge close the bank when they are granted. They are held back until the self-timed precharge at the end of the burst can no longer cut the row's minimum open time short. A sticky flag records requests that break the open/closed protocol.

Top module: `dram_bank_guard`

## Requirements
- R1: After reset every bank reads closed on `bank_open_o`, and `proto_err_o` is low.
- R2: A read or write to a bank is granted only while that bank is open, and no earlier than T_RCD cycles after the activate that opened it. An activate marks its bank open from the next cycle.
- R3: An activate to a bank that was closed by a precharge is granted no earlier than T_RP cycles after that precharge.
- R4: Two activates, to any banks, are at least T_RRD cycles apart.
- R5: A precharge of an open bank is granted no earlier than T_RAS cycles after that bank's activate.
- R6: A precharge of a bank is granted no earlier than BURST_LEN/2 + T_WR cycles after the last write to it.
- R7: A read to any bank is granted no earlier than BURST_LEN/2 + T_WTR cycles after the last write to any bank.
- R8: A read with auto precharge is granted no earlier than T_RAS − BURST_LEN/2 cycles after its activate. A write with auto precharge is granted no earlier than T_RAS − BURST_LEN/2 − T_WR cycles after its activate. Either one closes the bank at once. The next activate to that bank waits BURST_LEN/2 + T_RP cycles after an auto-precharge read, or BURST_LEN/2 + T_WR + T_RP cycles after an auto-precharge write.
- R9: After a mode load, no other command is granted for T_MRD cycles.
- R10: A mode load or a refresh is granted only when every bank is closed and its precharge time has passed. An activate after a refresh waits T_RFC cycles.
- R11: Precharge-all closes every bank, and each bank then waits T_RP cycles before its next activate.
- R12: An activate to an open bank, or a read or write to a closed bank, is never granted. It sets `proto_err_o`, which stays high until reset.
- R13: Command codes on `cmd_i` are: 0 idle, 1 activate, 2 read, 3 write, 4 read with auto precharge, 5 write with auto precharge, 6 precharge one bank, 7 precharge all, 8 mode load, 9 refresh. `bank_i` selects the bank. A held command is granted in the first cycle in which all of its rules are met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is offered |
| cmd_i | input | 4 | Command code (R13) |
| bank_i | input | BANK_W | Target bank |
| grant_o | output | 1 | Offered command is taken this cycle |
| bank_open_o | output | N_BANK | One bit per bank, set while a row is open |
| proto_err_o | output | 1 | Sticky protocol-violation flag |

## Verification
The bench sweeps the idle gap placed before a dependent command and checks the grant cycle against the rule's arithmetic minimum. A guard that counted one cycle too few would grant early, and one that counted one too many would stall an extra cycle. Every ordered pair of banks is tried for activate-to-activate spacing, which catches a guard that only spaces activates to the same bank. The auto-precharge cases check the open-time hold-off and the longer reopen delay. A design that closed the bank without stretching the precharge timer would reopen the bank too soon. Probes with a bank open show that mode load, refresh and protocol-breaking commands never get a grant.

// File: rtl/dram_bank_guard_pkg.sv
package dram_bank_guard_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_RDA  = 4'd4,
    CMD_WRA  = 4'd5,
    CMD_PRE  = 4'd6,
    CMD_PREA = 4'd7,
    CMD_LMR  = 4'd8,
    CMD_REF  = 4'd9
  } cmd_e;

  // defaults: ns limits rounded up at 7.5 ns
  localparam int D_RCD = 3;
  localparam int D_RP  = 3;
  localparam int D_RRD = 2;
  localparam int D_RAS = 6;
  localparam int D_WR  = 2;
  localparam int D_WTR = 1;
  localparam int D_MRD = 2;
  localparam int D_RFC = 10;
  localparam int D_BL  = 4;

  // spacing of n cycles -> counter load of n-1
  function automatic int ld(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction
endpackage

// File: rtl/dram_guard_timer.sv
module dram_guard_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, dec;

  assign dec   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
  assign cnt_o = cnt_q;

  // a load never shortens a pending wait
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i && val_i > dec) cnt_q <= val_i;
    else                            cnt_q <= dec;
  end
endmodule

// File: rtl/dram_guard_bank.sv
module dram_guard_bank
  import dram_bank_guard_pkg::*;
#(
  parameter int W       = 6,
  parameter int T_RCD   = D_RCD,
  parameter int T_RP    = D_RP,
  parameter int T_RAS   = D_RAS,
  parameter int T_WR    = D_WR,
  parameter int HALF_BL = D_BL / 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic wr_i,
  input  logic rda_i,
  input  logic wra_i,
  input  logic pre_i,
  output logic open_o,
  output logic ready_o,
  output logic col_ok_o,
  output logic rda_ok_o,
  output logic wra_ok_o,
  output logic pre_ok_o
);
  localparam logic [W-1:0] L_RCD = W'(ld(T_RCD));
  localparam logic [W-1:0] L_RAS = W'(ld(T_RAS));
  localparam logic [W-1:0] L_WR  = W'(ld(HALF_BL + T_WR));
  localparam logic [W-1:0] L_RP  = W'(ld(T_RP));
  localparam logic [W-1:0] L_RDA = W'(ld(HALF_BL + T_RP));
  localparam logic [W-1:0] L_WRA = W'(ld(HALF_BL + T_WR + T_RP));
  localparam logic [W-1:0] RDA_LIM = W'(HALF_BL);
  localparam logic [W-1:0] WRA_LIM = W'(HALF_BL + T_WR);

  logic         open_q;
  logic [W-1:0] rcd_c, ras_c, wr_c, rp_c, rp_val;

  assign rp_val = wra_i ? L_WRA : (rda_i ? L_RDA : L_RP);

  dram_guard_timer #(.W(W)) u_rcd (.clk_i, .rst_ni, .load_i(act_i), .val_i(L_RCD), .cnt_o(rcd_c));
  dram_guard_timer #(.W(W)) u_ras (.clk_i, .rst_ni, .load_i(act_i), .val_i(L_RAS), .cnt_o(ras_c));
  dram_guard_timer #(.W(W)) u_wr  (.clk_i, .rst_ni, .load_i(wr_i | wra_i), .val_i(L_WR), .cnt_o(wr_c));
  dram_guard_timer #(.W(W)) u_rp  (.clk_i, .rst_ni, .load_i(pre_i | rda_i | wra_i),
                                   .val_i(rp_val), .cnt_o(rp_c));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       open_q <= 1'b0;
    else if (act_i)                    open_q <= 1'b1;
    else if (pre_i | rda_i | wra_i)    open_q <= 1'b0;
  end

  assign open_o   = open_q;
  assign ready_o  = !open_q && rp_c == '0;
  assign col_ok_o = open_q && rcd_c == '0;
  // self-timed precharge must land at or after tRAS and write recovery
  assign rda_ok_o = ras_c <= RDA_LIM && wr_c <= RDA_LIM;
  assign wra_ok_o = ras_c <= WRA_LIM;
  assign pre_ok_o = !open_q || (ras_c == '0 && wr_c == '0);
endmodule

// File: rtl/dram_guard_shared.sv
module dram_guard_shared
  import dram_bank_guard_pkg::*;
#(
  parameter int W       = 6,
  parameter int T_RRD   = D_RRD,
  parameter int T_WTR   = D_WTR,
  parameter int T_MRD   = D_MRD,
  parameter int T_RFC   = D_RFC,
  parameter int HALF_BL = D_BL / 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic wr_i,
  input  logic lmr_i,
  input  logic ref_i,
  output logic rrd_ok_o,
  output logic wtr_ok_o,
  output logic mrd_ok_o,
  output logic rfc_ok_o
);
  localparam logic [W-1:0] L_RRD = W'(ld(T_RRD));
  localparam logic [W-1:0] L_WTR = W'(ld(HALF_BL + T_WTR));
  localparam logic [W-1:0] L_MRD = W'(ld(T_MRD));
  localparam logic [W-1:0] L_RFC = W'(ld(T_RFC));

  logic [W-1:0] rrd_c, wtr_c, mrd_c, rfc_c;

  dram_guard_timer #(.W(W)) u_rrd (.clk_i, .rst_ni, .load_i(act_i), .val_i(L_RRD), .cnt_o(rrd_c));
  dram_guard_timer #(.W(W)) u_wtr (.clk_i, .rst_ni, .load_i(wr_i),  .val_i(L_WTR), .cnt_o(wtr_c));
  dram_guard_timer #(.W(W)) u_mrd (.clk_i, .rst_ni, .load_i(lmr_i), .val_i(L_MRD), .cnt_o(mrd_c));
  dram_guard_timer #(.W(W)) u_rfc (.clk_i, .rst_ni, .load_i(ref_i), .val_i(L_RFC), .cnt_o(rfc_c));

  assign rrd_ok_o = rrd_c == '0;
  assign wtr_ok_o = wtr_c == '0;
  assign mrd_ok_o = mrd_c == '0;
  assign rfc_ok_o = rfc_c == '0;
endmodule

// File: rtl/dram_bank_guard.sv
module dram_bank_guard
  import dram_bank_guard_pkg::*;
#(
  parameter int N_BANK    = 4,
  parameter int T_RCD     = D_RCD,
  parameter int T_RP      = D_RP,
  parameter int T_RRD     = D_RRD,
  parameter int T_RAS     = D_RAS,
  parameter int T_WR      = D_WR,
  parameter int T_WTR     = D_WTR,
  parameter int T_MRD     = D_MRD,
  parameter int T_RFC     = D_RFC,
  parameter int BURST_LEN = D_BL,
  localparam int BANK_W   = $clog2(N_BANK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              grant_o,
  output logic [N_BANK-1:0] bank_open_o,
  output logic              proto_err_o
);
  localparam int HALF_BL = BURST_LEN / 2;
  localparam int MAX_LD  = T_RCD + T_RP + T_RRD + T_RAS + T_WR + T_WTR + T_MRD + T_RFC + HALF_BL;
  localparam int CNT_W   = $clog2(MAX_LD + 1);

  cmd_e cmd;
  logic legal, bad, err_q;
  logic rrd_ok, wtr_ok, mrd_ok, rfc_ok;
  logic [N_BANK-1:0] open, ready, col_ok, rda_ok, wra_ok, pre_ok;
  logic [N_BANK-1:0] act_go, wr_go, rda_go, wra_go, pre_go;

  assign cmd = cmd_e'(cmd_i);

  always_comb begin
    case (cmd)
      CMD_NOP:          legal = 1'b1;
      CMD_ACT:          legal = ready[bank_i] && rrd_ok && rfc_ok;
      CMD_RD:           legal = col_ok[bank_i] && wtr_ok;
      CMD_RDA:          legal = col_ok[bank_i] && wtr_ok && rda_ok[bank_i];
      CMD_WR:           legal = col_ok[bank_i];
      CMD_WRA:          legal = col_ok[bank_i] && wra_ok[bank_i];
      CMD_PRE:          legal = pre_ok[bank_i];
      CMD_PREA:         legal = &pre_ok;
      CMD_LMR, CMD_REF: legal = &ready && rfc_ok;
      default:          legal = 1'b0;
    endcase
    if (cmd != CMD_NOP && !mrd_ok) legal = 1'b0;
  end

  assign grant_o = cmd_valid_i && legal;

  always_comb begin
    bad = 1'b0;
    if (cmd_valid_i) begin
      if (cmd == CMD_ACT && open[bank_i]) bad = 1'b1;
      if ((cmd == CMD_RD || cmd == CMD_WR || cmd == CMD_RDA || cmd == CMD_WRA) && !open[bank_i])
        bad = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (bad) err_q <= 1'b1;
  end

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic hit;
    assign hit       = grant_o && bank_i == BANK_W'(b);
    assign act_go[b] = hit && cmd == CMD_ACT;
    assign wr_go[b]  = hit && cmd == CMD_WR;
    assign rda_go[b] = hit && cmd == CMD_RDA;
    assign wra_go[b] = hit && cmd == CMD_WRA;
    assign pre_go[b] = (hit && cmd == CMD_PRE) || (grant_o && cmd == CMD_PREA);

    dram_guard_bank #(
      .W(CNT_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_WR(T_WR), .HALF_BL(HALF_BL)
    ) u_bank (
      .clk_i, .rst_ni,
      .act_i(act_go[b]), .wr_i(wr_go[b]), .rda_i(rda_go[b]), .wra_i(wra_go[b]), .pre_i(pre_go[b]),
      .open_o(open[b]), .ready_o(ready[b]), .col_ok_o(col_ok[b]),
      .rda_ok_o(rda_ok[b]), .wra_ok_o(wra_ok[b]), .pre_ok_o(pre_ok[b])
    );
  end

  dram_guard_shared #(
    .W(CNT_W), .T_RRD(T_RRD), .T_WTR(T_WTR), .T_MRD(T_MRD), .T_RFC(T_RFC), .HALF_BL(HALF_BL)
  ) u_shared (
    .clk_i, .rst_ni,
    .act_i(grant_o && cmd == CMD_ACT),
    .wr_i(grant_o && (cmd == CMD_WR || cmd == CMD_WRA)),
    .lmr_i(grant_o && cmd == CMD_LMR),
    .ref_i(grant_o && cmd == CMD_REF),
    .rrd_ok_o(rrd_ok), .wtr_ok_o(wtr_ok), .mrd_ok_o(mrd_ok), .rfc_ok_o(rfc_ok)
  );

  assign bank_open_o = open;
  assign proto_err_o = err_q;
endmodule

// File: rtl/dram_bank_guard_chk.sv
module dram_bank_guard_chk
  import dram_bank_guard_pkg::*;
#(
  parameter int N_BANK = 4,
  parameter int T_RRD  = D_RRD,
  parameter int T_MRD  = D_MRD,
  localparam int BANK_W = $clog2(N_BANK)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [3:0]        cmd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic              grant_o,
  input logic [N_BANK-1:0] bank_open_o,
  input logic              proto_err_o
);
  logic [7:0] since_act, since_lmr;
  logic act_seen, lmr_seen, take;

  assign take = cmd_valid_i && grant_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= '0; since_lmr <= '0; act_seen <= 1'b0; lmr_seen <= 1'b0;
    end else begin
      if (take && cmd_i == CMD_ACT) begin since_act <= 8'd1; act_seen <= 1'b1; end
      else if (since_act != 8'hff) since_act <= since_act + 8'd1;
      if (take && cmd_i == CMD_LMR) begin since_lmr <= 8'd1; lmr_seen <= 1'b1; end
      else if (since_lmr != 8'hff) since_lmr <= since_lmr + 8'd1;
    end
  end

  p_col_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (cmd_i == CMD_RD || cmd_i == CMD_WR || cmd_i == CMD_RDA || cmd_i == CMD_WRA))
    |-> bank_open_o[bank_i]);
  p_act_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_i == CMD_ACT) |=> bank_open_o[$past(bank_i)]);
  p_act_closed_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_i == CMD_ACT) |-> !bank_open_o[bank_i]);
  p_ap_closes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (cmd_i == CMD_RDA || cmd_i == CMD_WRA)) |=> !bank_open_o[$past(bank_i)]);
  p_prea_closes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_i == CMD_PREA) |=> bank_open_o == '0);
  p_err_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
  p_rrd_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_i == CMD_ACT && act_seen) |-> int'(since_act) >= T_RRD);
  p_mrd_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_i != CMD_NOP && lmr_seen) |-> int'(since_lmr) >= T_MRD);
  p_idle_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (cmd_i == CMD_LMR || cmd_i == CMD_REF)) |-> bank_open_o == '0);
endmodule

bind dram_bank_guard dram_bank_guard_chk #(.N_BANK(N_BANK), .T_RRD(T_RRD), .T_MRD(T_MRD)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i), .bank_i(bank_i),
  .grant_o(grant_o), .bank_open_o(bank_open_o), .proto_err_o(proto_err_o)
);

// File: tb/dram_bank_guard_tb_top.sv
module dram_bank_guard_tb_top;
  import dram_bank_guard_pkg::*;

  localparam int NB = 4;
  localparam int RCD = D_RCD, RP = D_RP, RRD = D_RRD, RAS = D_RAS, TWR = D_WR;
  localparam int WTR = D_WTR, MRD = D_MRD, RFC = D_RFC, HB = D_BL / 2;

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0;
  logic [3:0] cmd = 4'd0;
  logic [1:0] bank = 2'd0;
  logic gnt, err;
  logic [NB-1:0] opn;
  int cyc = 0, total = 0, fails = 0;

  dram_bank_guard #(
    .N_BANK(NB), .T_RCD(RCD), .T_RP(RP), .T_RRD(RRD), .T_RAS(RAS), .T_WR(TWR),
    .T_WTR(WTR), .T_MRD(MRD), .T_RFC(RFC), .BURST_LEN(D_BL)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(vld), .cmd_i(cmd), .bank_i(bank),
    .grant_o(gnt), .bank_open_o(opn), .proto_err_o(err)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 150000) begin
    total++; fails++;
    $display("FAIL R13 watchdog: actual %0d expected below 150000", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input int act, input int exp, input string msg);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic idle(input int n);
    if (n > 0) begin
      @(negedge clk); vld = 1'b0; cmd = 4'd0;
      repeat (n) @(posedge clk);
    end
  endtask

  task automatic issue(input logic [3:0] c, input int b, output int gc);
    int w;
    w = 0;
    @(negedge clk); vld = 1'b1; cmd = c; bank = 2'(b); #1;
    while (!gnt && w < 100) begin @(negedge clk); #1; w++; end
    gc = cyc;
    @(posedge clk);
  endtask

  task automatic probe(input logic [3:0] c, input int b, input int n, output int g);
    g = 0;
    @(negedge clk); vld = 1'b1; cmd = c; bank = 2'(b);
    for (int k = 0; k < n; k++) begin #1; if (gnt) g++; @(negedge clk); end
    vld = 1'b0; cmd = 4'd0;
  endtask

  initial begin
    int a, a1, a2, r, w, p, l, f, g;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(int'(opn), 0, "R1 banks closed after reset");
    check(int'(err), 0, "R1 error clear after reset");

    // activate-to-column and activate-to-precharge, sweeping the gap
    for (int gap = 0; gap < 5; gap++) begin
      idle(20);
      issue(CMD_ACT, gap % NB, a);
      idle(gap);
      issue(CMD_RD, gap % NB, r);
      check(r, mx(a + 1 + gap, a + RCD), "R2 act to read spacing");
      issue(CMD_PRE, gap % NB, p);
      check(p, mx(r + 1, a + RAS), "R5 act to precharge spacing");
    end

    // precharge-to-activate, sweeping the gap
    for (int gap = 0; gap < 5; gap++) begin
      idle(20);
      issue(CMD_ACT, 1, a);
      issue(CMD_PRE, 1, p);
      check(p, a + RAS, "R5 precharge held for row open time");
      idle(gap);
      issue(CMD_ACT, 1, a2);
      check(a2, mx(p + 1 + gap, p + RP), "R3 precharge to act spacing");
      issue(CMD_PRE, 1, p);
      check(p, a2 + RAS, "R5 second precharge");
    end

    // every ordered bank pair
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NB; j++) if (i != j) begin
        idle(20);
        issue(CMD_ACT, i, a);
        issue(CMD_ACT, j, a2);
        check(a2, a + RRD, "R4 act to act across banks");
        #2 check(int'(opn), (1 << i) | (1 << j), "R13 open mask after two activates");
        issue(CMD_PREA, 0, p);
        check(p, a2 + RAS, "R11 precharge-all waits row open time");
        #2 check(int'(opn), 0, "R11 precharge-all closes every bank");
      end
    issue(CMD_ACT, 2, a);
    check(a, p + RP, "R11 act after precharge-all waits tRP");
    issue(CMD_PRE, 2, p);

    // write recovery
    idle(20);
    issue(CMD_ACT, 0, a);
    issue(CMD_WR, 0, w);
    check(w, a + RCD, "R2 act to write spacing");
    issue(CMD_PRE, 0, p);
    check(p, mx(w + HB + TWR, a + RAS), "R6 write recovery before precharge");

    // write-to-read turnaround across banks
    idle(20);
    issue(CMD_ACT, 0, a);
    issue(CMD_ACT, 1, a1);
    issue(CMD_WR, 0, w);
    check(w, mx(a1 + 1, a + RCD), "R2 write after second activate");
    issue(CMD_RD, 1, r);
    check(r, mx(mx(w + 1, w + HB + WTR), a1 + RCD), "R7 write to read turnaround");
    issue(CMD_PREA, 0, p);
    check(p, mx(mx(r + 1, a1 + RAS), w + HB + TWR), "R6 precharge-all after write");

    // auto precharge read, sweeping the gap
    for (int gap = 0; gap < 5; gap++) begin
      idle(20);
      issue(CMD_ACT, 2, a);
      idle(gap);
      issue(CMD_RDA, 2, r);
      check(r, mx(mx(a + 1 + gap, a + RCD), a + RAS - HB), "R8 read-autoprecharge hold-off");
      #2 check(int'(opn[2]), 0, "R8 read-autoprecharge closes bank");
      issue(CMD_ACT, 2, a2);
      check(a2, r + HB + RP, "R8 reopen after read-autoprecharge");
      issue(CMD_WRA, 2, w);
      check(w, mx(mx(a2 + 1, a2 + RCD), a2 + RAS - HB - TWR), "R8 write-autoprecharge hold-off");
      issue(CMD_ACT, 2, a);
      check(a, w + HB + TWR + RP, "R8 reopen after write-autoprecharge");
      issue(CMD_PRE, 2, p);
    end

    // mode load
    idle(20);
    issue(CMD_LMR, 0, l);
    issue(CMD_ACT, 1, a);
    check(a, mx(l + 1, l + MRD), "R9 nothing granted inside mode-load time");
    issue(CMD_PRE, 1, p);
    issue(CMD_LMR, 0, l);
    check(l, p + RP, "R10 mode load waits precharge time");
    issue(CMD_ACT, 0, a);
    check(a, l + MRD, "R9 act after mode load");
    probe(CMD_LMR, 0, 4, g);
    check(g, 0, "R10 mode load refused with open bank");
    probe(CMD_REF, 0, 4, g);
    check(g, 0, "R10 refresh refused with open bank");
    issue(CMD_PRE, 0, p);

    // refresh
    idle(20);
    issue(CMD_REF, 0, f);
    issue(CMD_ACT, 1, a);
    check(a, f + RFC, "R10 act after refresh");
    issue(CMD_PRE, 1, p);

    // protocol errors
    idle(20);
    #1 check(int'(err), 0, "R12 no error from legal traffic");
    issue(CMD_ACT, 3, a);
    probe(CMD_ACT, 3, 3, g);
    check(g, 0, "R12 act to open bank refused");
    #1 check(int'(err), 1, "R12 error raised");
    probe(CMD_RD, 2, 3, g);
    check(g, 0, "R12 read to closed bank refused");
    probe(CMD_WR, 0, 3, g);
    check(g, 0, "R12 write to closed bank refused");
    idle(5);
    #1 check(int'(err), 1, "R12 error sticky");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule